// File: doc/BRIEF.md
# Latched 64-bit Compare Timer

A system timer peripheral on a 32-bit register bus. A 64-bit counter runs freely, advancing once per prescaler period derived from the input clock. Software obtains a coherent 64-bit reading by writing a snapshot command and then reading two latched words, which cannot tear across a carry. The counter words are also writable, so the count can be cleared or restored after a power-down.

Six 32-bit compare channels watch the low counter word. Each one raises a sticky status flag when it matches. Enabled flags are ORed into a level interrupt. The last channel can also act as a watchdog: while its enable is set, a match produces a one-cycle reset request.

Top module: `tick_timer64`

## Requirements
- R1: After reset every register reads zero except status. Status reads 0x3F because the zero counter matches every zero compare. The snapshot command offset 0x30 and an unused offset such as 0x3C always read zero.
- R2: With divider value D at offset 0x2C, the counter advances by one every 2*(D+1) clock cycles, counted from the last counter write.
- R3: The count is 64 bits wide. A carry out of the low word (offset 0x00) increments the high word (offset 0x04).
- R4: A write to the counter low or high word loads that half in the same cycle and overrides the increment for that cycle. The write also restarts the prescaler phase. The half that is not written is kept.
- R5: Writing a value with bit 0 set to offset 0x30 copies all 64 counter bits, as they were before that edge, into the snapshot words at 0x34 (low) and 0x38 (high). A write with bit 0 clear leaves the snapshot unchanged.
- R6: Compare register n sits at offset 0x08+4n, for n from 0 to 5. Status bit n at offset 0x20 is set in the cycle after the low counter word equals compare n.
- R7: Writing 1 to status bit n clears that bit. Writing 0 leaves it unchanged. If a match is present in the cycle of the clear, the bit stays set.
- R8: `irq` is high exactly while some status bit n and enable bit n (offset 0x24) are both set.
- R9: With bit 0 of offset 0x28 set, the first cycle in which channel 5 matches produces a `wdt_rst` pulse one clock long. With that bit clear, no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt |
| wdt_rst | output | 1 | One-cycle watchdog reset request |

## Verification
The assertions assume each write strobe lasts one cycle with a stable address and data. They also assume the watchdog enable is not toggled in the same cycle that channel 5 first matches. The stimulus drives every write for exactly one clock, from one falling edge to the next. It writes the divider only while the counter is about to be reloaded, so the prescaler phase in use is always known. Each snapshot, compare and watchdog scenario starts from a fresh counter load, so the expected edge of every event can be counted from the load.

// File: rtl/tick_timer64.sv
module tick_timer64 #(
  parameter int DIV_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        wdt_rst
);
  localparam int N_CMP = 6;
  localparam int WD_CH = N_CMP - 1;
  localparam logic [5:0] A_CLO = 6'h00, A_CHI = 6'h04, A_CMP0 = 6'h08,
                         A_STAT = 6'h20, A_IEN = 6'h24, A_WDEN = 6'h28,
                         A_DIV = 6'h2C, A_SNAP = 6'h30, A_SLO = 6'h34, A_SHI = 6'h38;

  logic [63:0]                  cnt, lat;
  logic [N_CMP-1:0][31:0]       cmp;
  logic [N_CMP-1:0]             st, ien, match;
  logic                         wden, wd_q;
  logic [DIV_W-1:0]             div;
  logic [DIV_W:0]               ph;

  wire w_lo   = bus_wr && bus_addr == A_CLO;
  wire w_hi   = bus_wr && bus_addr == A_CHI;
  wire w_st   = bus_wr && bus_addr == A_STAT;
  wire w_snap = bus_wr && bus_addr == A_SNAP && bus_wdata[0];
  wire tick   = ph == {div, 1'b1};

  for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
    assign match[i] = cnt[31:0] == cmp[i];
  end

  assign irq = |(st & ien);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; ph <= '0; lat <= '0; cmp <= '0; st <= '0;
      ien <= '0; wden <= 1'b0; div <= '0; wd_q <= 1'b0; wdt_rst <= 1'b0;
    end else begin
      if (w_lo || w_hi) begin
        ph <= '0;
        if (w_lo) cnt[31:0]  <= bus_wdata;
        if (w_hi) cnt[63:32] <= bus_wdata;
      end else if (tick) begin
        ph  <= '0;
        cnt <= cnt + 64'd1;
      end else begin
        ph <= ph + 1'b1;
      end
      if (w_snap) lat <= cnt;
      for (int i = 0; i < N_CMP; i++)
        if (bus_wr && bus_addr == A_CMP0 + 6'(4 * i)) cmp[i] <= bus_wdata;
      st <= (st & ~(w_st ? bus_wdata[N_CMP-1:0] : '0)) | match;
      if (bus_wr && bus_addr == A_IEN)  ien  <= bus_wdata[N_CMP-1:0];
      if (bus_wr && bus_addr == A_WDEN) wden <= bus_wdata[0];
      if (bus_wr && bus_addr == A_DIV)  div  <= bus_wdata[DIV_W-1:0];
      wd_q    <= match[WD_CH];
      wdt_rst <= wden && match[WD_CH] && !wd_q;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CLO:  bus_rdata = cnt[31:0];
      A_CHI:  bus_rdata = cnt[63:32];
      A_STAT: bus_rdata = 32'(st);
      A_IEN:  bus_rdata = 32'(ien);
      A_WDEN: bus_rdata = {31'd0, wden};
      A_DIV:  bus_rdata = 32'(div);
      A_SLO:  bus_rdata = lat[31:0];
      A_SHI:  bus_rdata = lat[63:32];
      default: ;
    endcase
    for (int i = 0; i < N_CMP; i++)
      if (bus_addr == A_CMP0 + 6'(4 * i)) bus_rdata = cmp[i];
  end
endmodule

// File: rtl/tick_timer64_chk.sv
module tick_timer64_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [5:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic        wdt_rst,
  input logic [63:0] cnt,
  input logic [63:0] lat,
  input logic [5:0]  st,
  input logic        wden
);
  wire snap_cmd = bus_wr && bus_addr == 6'h30 && bus_wdata[0];
  wire cnt_wr   = bus_wr && (bus_addr == 6'h00 || bus_addr == 6'h04);

  AST_SNAP_COHERENT: assert property (@(posedge clk) disable iff (!rst_n) snap_cmd |=> lat == $past(cnt)); // R5
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !snap_cmd |=> $stable(lat)); // R5
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) !cnt_wr |=> (cnt == $past(cnt) || cnt == $past(cnt) + 64'd1)); // R2
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (bus_wr && bus_addr == 6'h00) |=> cnt[31:0] == $past(bus_wdata)); // R4
  AST_WDT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) wdt_rst |=> !wdt_rst); // R9
  AST_WDT_GATED: assert property (@(posedge clk) disable iff (!rst_n) wdt_rst |-> $past(wden)); // R9

  for (genvar i = 0; i < 6; i++) begin : g_st
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (st[i] && !(bus_wr && bus_addr == 6'h20 && bus_wdata[i])) |=> st[i]); // R7
  end
endmodule

bind tick_timer64 tick_timer64_chk i_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .wdt_rst(wdt_rst), .cnt(cnt), .lat(lat),
  .st(st), .wden(wden)
);

// File: tb/test_tick_timer64.sv
module test_tick_timer64;
  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, irq, wdt_rst;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;

  always #4 clk = ~clk;

  tick_timer64 i_tick_timer64 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .wdt_rst(wdt_rst));

  typedef struct { int kind; logic [31:0] exp; logic [31:0] mask; string tag; } item_t;
  item_t q[$];
  event  sample_ev;
  int    checks = 0, fails = 0, cyc = 0, wrc = 0, mdiv = 0;
  logic [63:0] base = '0;
  bit    done = 0;

  always @(posedge clk) cyc++;

  function automatic logic [63:0] cur();
    return base + 64'((cyc - wrc) / (2 * (mdiv + 1)));
  endfunction

  always @(sample_ev) begin
    item_t it;
    logic [31:0] v;
    it = q.pop_front();
    v = (it.kind == 0) ? bus_rdata : (it.kind == 1) ? {31'd0, irq} : {31'd0, wdt_rst};
    checks++;
    if ((v & it.mask) != (it.exp & it.mask)) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", it.tag, v & it.mask, it.exp & it.mask);
    end
  end

  task automatic expect_item(int kind, logic [31:0] e, logic [31:0] m, string tag);
    q.push_back('{kind, e, m, tag});
    #1 -> sample_ev;
    @(negedge clk);
  endtask

  task automatic rd(logic [5:0] a, logic [31:0] e, logic [31:0] m, string tag);
    bus_addr = a;
    expect_item(0, e, m, tag);
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    logic [63:0] pre;
    pre = cur();
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a == 6'h2C) mdiv = int'(d);
    if (a == 6'h00) begin base = {pre[63:32], d}; wrc = cyc; end
    if (a == 6'h04) begin base = {d, pre[31:0]}; wrc = cyc; end
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; wrc = cyc;
    rd(6'h2C, 0, '1, "R1 divider");
    rd(6'h24, 0, '1, "R1 enable");
    rd(6'h28, 0, '1, "R1 wdog enable");
    rd(6'h14, 0, '1, "R1 compare3");
    rd(6'h34, 0, '1, "R1 snapshot low");
    rd(6'h30, 0, '1, "R1 command reads zero");
    rd(6'h3C, 0, '1, "R1 unused offset");
    rd(6'h20, 32'h3F, '1, "R1 R6 status after reset");
    expect_item(1, 0, 1, "R1 irq low");

    wr(6'h2C, 2); wr(6'h00, 100); wr(6'h04, 5);
    rd(6'h00, cur()[31:0], '1, "R4 load low");
    repeat (7) @(negedge clk);
    rd(6'h00, cur()[31:0], '1, "R2 one period");
    rd(6'h04, 5, '1, "R4 load high");
    repeat (11) @(negedge clk);
    rd(6'h00, cur()[31:0], '1, "R2 several periods");

    wr(6'h00, 32'hFFFF_FFFE); wr(6'h04, 7);
    repeat (13) @(negedge clk);
    rd(6'h04, cur()[63:32], '1, "R3 carry high");
    rd(6'h00, cur()[31:0], '1, "R3 carry low");

    wr(6'h00, 32'hFFFF_FFFF); wr(6'h04, 1);
    repeat (3) @(negedge clk);
    snap = cur();
    wr(6'h30, 1);
    repeat (10) @(negedge clk);
    rd(6'h34, snap[31:0], '1, "R5 snapshot low");
    rd(6'h38, snap[63:32], '1, "R5 snapshot high");
    rd(6'h04, cur()[63:32], '1, "R3 live high after carry");
    wr(6'h30, 2);
    repeat (6) @(negedge clk);
    rd(6'h34, snap[31:0], '1, "R5 bit0 clear ignored");

    wr(6'h2C, 0); wr(6'h00, 50); wr(6'h04, 0);
    wr(6'h20, 32'h3F);
    wr(6'h10, 60);
    repeat (30) @(negedge clk);
    rd(6'h20, 32'h04, 32'h3F, "R6 compare2 match");
    expect_item(1, 0, 1, "R8 irq gated off");
    wr(6'h24, 4);
    expect_item(1, 1, 1, "R8 irq on");
    wr(6'h20, 0);
    rd(6'h20, 32'h04, 32'h3F, "R7 zero write no effect");
    wr(6'h20, 4);
    rd(6'h20, 0, 32'h3F, "R7 clear");
    expect_item(1, 0, 1, "R8 irq off after clear");

    wr(6'h2C, 9); wr(6'h0C, 200); wr(6'h00, 200); wr(6'h04, 0);
    wr(6'h20, 2);
    rd(6'h20, 2, 2, "R7 match wins over clear");
    expect_item(1, 0, 1, "R8 bit1 not enabled");
    wr(6'h24, 6);
    expect_item(1, 1, 1, "R8 bit1 enabled");
    repeat (25) @(negedge clk);
    wr(6'h20, 2);
    rd(6'h20, 0, 2, "R7 clear after match");
    expect_item(1, 0, 1, "R8 irq drops");

    wr(6'h24, 0); wr(6'h2C, 0); wr(6'h1C, 300); wr(6'h28, 1);
    wr(6'h00, 290); wr(6'h04, 0);
    for (int k = 0; k < 30; k++)
      expect_item(2, {31'd0, (cyc - wrc) == 21}, 1, "R9 wdt pulse");
    wr(6'h28, 0); wr(6'h00, 290);
    for (int k = 0; k < 30; k++)
      expect_item(2, 0, 1, "R9 wdt disabled");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule